// File: doc/BRIEF.md
# Code Rate NCO with Preset

This block is a numerically controlled oscillator that paces a spreading-code generator. A 25-bit phase accumulator adds a programmable frequency word on every sample enable. Each carry out of the accumulator produces a one-cycle half-chip tick, so the tick rate is twice the chip rate. A toggle flop pairs the ticks and raises a chip strobe on every second tick, which marks a chip boundary for the downstream code generator. With the default width, one LSB of the frequency word is worth about 85.15 mHz at the usual sample clock. A word near the nominal 2.046 MHz half-chip rate gives 1.023 Mchip/s.

Software writes through a single bus port. A select bit picks the frequency word or the phase. A new frequency word can be written at any time and never disturbs the phase. A phase write takes effect only while the preset-mode input is high. It then loads an exact phase, restarts the chip pairing and suppresses any tick that would have fallen in that cycle. In update mode (preset mode low), phase writes are dropped, and alignment has to be made by steering the frequency.

Top module: `code_nco`

## Requirements
- R1: After reset the phase and the frequency word are zero, the tick pairing restarts, and half_tick and chip_strobe are low.
- R2: On each cycle with samp_en high, the phase advances by the frequency word modulo 2^25. Without samp_en, and without a preset load, the phase holds.
- R3: half_tick is high for exactly one cycle: the cycle after a sample enable whose addition carried out of bit 24. It is never high in the cycle after a cycle without samp_en.
- R4: chip_strobe rises together with the 2nd, 4th, 6th... half_tick counted from reset or from the last preset load, and is never high without half_tick.
- R5: A write with wr_sel = 0 loads the frequency word from wr_data, in either mode. A sample enable in the same cycle still uses the old word, and the write never alters the phase.
- R6: A write with wr_sel = 1 while preset_mode = 1 loads the phase with wr_data and restarts the tick pairing. It holds both outputs low in the following cycle, even when samp_en was high and the addition would have carried.
- R7: A write with wr_sel = 1 while preset_mode = 0 has no effect on the phase.
- R8: Over N sample enables that start from phase P with a fixed word W, the number of half_ticks is floor((P + N*W) / 2^25) and the number of chip_strobes is half of that, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Sample enable; one accumulation per high cycle |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 1 | Write target: 0 frequency word, 1 phase |
| wr_data | input | 25 | Write data |
| preset_mode | input | 1 | 1 enables phase loads (preset mode), 0 is update mode |
| half_tick | output | 1 | One-cycle pulse per accumulator carry (twice chip rate) |
| chip_strobe | output | 1 | One-cycle pulse on every second half_tick |

## Verification
Both outputs are registered, so a tick caused by the sample enable at clock edge k is seen in the cycle that follows edge k and is gone one cycle later. Writes act at the same edge as the enable, so a frequency write affects only the additions after that edge, and a preset decides the outputs of the next cycle. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which is one cycle after the edge that made them. Rate checks count pulses on falling edges and allow one extra cycle after the last enable before reading the counts.

// File: rtl/code_nco_pkg.sv
package code_nco_pkg;

  // Default accumulator width, shared by the top and the bench
  localparam int unsigned NCO_W_DEF = 25;

  // Bus write target
  typedef enum logic {
    TGT_FREQ  = 1'b0,
    TGT_PHASE = 1'b1
  } wr_target_e;

endpackage

// File: rtl/code_nco_wrdec.sv
module code_nco_wrdec
  import code_nco_pkg::*;
#(
  parameter int unsigned W = NCO_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  wr_target_e   wr_tgt,
  input  logic [W-1:0] wr_data,
  input  logic         preset_mode,
  output logic [W-1:0] freq_word,
  output logic         freq_we,
  output logic         preset_load
);

  assign freq_we     = wr_en && (wr_tgt == TGT_FREQ);
  assign preset_load = wr_en && (wr_tgt == TGT_PHASE) && preset_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_word <= '0;
    end else if (freq_we) begin
      freq_word <= wr_data;
    end
  end

  // R5
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_we |=> $stable(freq_word));

endmodule

// File: rtl/code_nco_accum.sv
module code_nco_accum #(
  parameter int unsigned W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         samp_en,
  input  logic         preset_load,
  input  logic [W-1:0] preset_val,
  input  logic [W-1:0] freq_word,
  output logic [W-1:0] phase,
  output logic         carry_evt
);

  // One accumulation: returns {carry, new phase}
  function automatic logic [W:0] acc_step(input logic [W-1:0] ph,
                                          input logic [W-1:0] inc);
    return {1'b0, ph} + {1'b0, inc};
  endfunction

  logic [W:0] step;

  assign step      = acc_step(phase, freq_word);
  assign carry_evt = samp_en && step[W] && !preset_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (preset_load) begin
      phase <= preset_val;
    end else if (samp_en) begin
      phase <= step[W-1:0];
    end
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_en && !preset_load) |=> $stable(phase));

  // R6
  preset_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> (phase == $past(preset_val)));

endmodule

// File: rtl/code_nco_tickgen.sv
module code_nco_tickgen (
  input  logic clk,
  input  logic rst_n,
  input  logic carry_evt,
  input  logic preset_load,
  output logic half_tick,
  output logic chip_strobe
);

  logic second_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_half <= 1'b0;
      half_tick   <= 1'b0;
      chip_strobe <= 1'b0;
    end else if (preset_load) begin
      second_half <= 1'b0;
      half_tick   <= 1'b0;
      chip_strobe <= 1'b0;
    end else begin
      half_tick   <= carry_evt;
      chip_strobe <= carry_evt && second_half;
      if (carry_evt) begin
        second_half <= !second_half;
      end
    end
  end

  // R4
  strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_strobe |-> half_tick);

  // R4
  no_double_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_strobe && !preset_load) |=> !chip_strobe);

endmodule

// File: rtl/code_nco.sv
module code_nco
  import code_nco_pkg::*;
#(
  parameter int unsigned W = NCO_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         samp_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         preset_mode,
  output logic         half_tick,
  output logic         chip_strobe
);

  logic [W-1:0] freq_word;
  logic [W-1:0] phase;
  logic         freq_we;
  logic         preset_load;
  logic         carry_evt;
  wr_target_e   wr_tgt;

  assign wr_tgt = wr_target_e'(wr_sel);

  code_nco_wrdec #(.W(W)) u_wrdec (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_tgt      (wr_tgt),
    .wr_data     (wr_data),
    .preset_mode (preset_mode),
    .freq_word   (freq_word),
    .freq_we     (freq_we),
    .preset_load (preset_load)
  );

  code_nco_accum #(.W(W)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .samp_en     (samp_en),
    .preset_load (preset_load),
    .preset_val  (wr_data),
    .freq_word   (freq_word),
    .phase       (phase),
    .carry_evt   (carry_evt)
  );

  code_nco_tickgen u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .carry_evt   (carry_evt),
    .preset_load (preset_load),
    .half_tick   (half_tick),
    .chip_strobe (chip_strobe)
  );

  // R3
  tick_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> $past(samp_en));

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !samp_en) |=> !half_tick);

  // R6
  preset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> (!half_tick && !chip_strobe));

  // R7
  update_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !preset_mode && !samp_en) |=> $stable(phase));

endmodule

// File: tb/code_nco_test.sv
module code_nco_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 25;
  localparam longint MOD = 64'd1 << W;

  // Rate table (R8): start phase, frequency word, sample count
  localparam int NV = 5;
  localparam longint VP0 [NV] = '{0, 33554431, 0, 16777216, 0};
  localparam longint VINC[NV] = '{16777216, 1, 33554431, 25165824, 0};
  localparam int     VN  [NV] = '{10, 1, 40, 12, 20};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         samp_en = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         preset_mode = 1'b0;
  logic         half_tick;
  logic         chip_strobe;

  int checks = 0;
  int errors = 0;
  int n_tick = 0;
  int n_chip = 0;

  code_nco #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .preset_mode(preset_mode),
    .half_tick(half_tick), .chip_strobe(chip_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (half_tick)   n_tick = n_tick + 1;
    if (chip_strobe) n_chip = n_chip + 1;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counters are cleared only on a falling edge where both outputs are low
  task automatic clr();
    n_tick = 0;
    n_chip = 0;
  endtask

  task automatic set_freq(input longint v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; preset_mode = 1'b0; wr_data = W'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic preset(input longint p);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; preset_mode = 1'b1; wr_data = W'(p);
    @(negedge clk);
    wr_en = 1'b0; preset_mode = 1'b0;
    clr();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      samp_en = 1'b1;
    end
    @(negedge clk);
    samp_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs low after reset, word zero gives no ticks
    chk("R1 half_tick after reset", half_tick, 0);
    chk("R1 chip_strobe after reset", chip_strobe, 0);
    clr();
    run(20);
    chk("R1 no ticks with reset word", n_tick, 0);
    // R1/R2: phase starts at zero, two half-scale steps carry once
    set_freq(MOD / 2);
    clr();
    run(2);
    chk("R2 ticks from reset phase", n_tick, 1);

    // Table walk: R8 rate, R4 pairing restart after preset
    for (int v = 0; v < NV; v++) begin
      longint tot;
      set_freq(VINC[v]);
      preset(VP0[v]);
      run(VN[v]);
      tot = (VP0[v] + longint'(VN[v]) * VINC[v]) / MOD;
      chk("R8 half_tick count", n_tick, tot);
      chk("R4 chip_strobe count", n_chip, tot / 2);
    end

    // R3 and R5: same-cycle word write uses old word, tick lasts one cycle
    set_freq(0);
    preset(MOD - 1);
    @(negedge clk);
    samp_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = W'(1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 old word used in write cycle", half_tick, 0);
    @(negedge clk);
    samp_en = 1'b0;
    chk("R3 tick after carrying sample", half_tick, 1);
    @(negedge clk);
    chk("R3 tick is one cycle wide", half_tick, 0);

    // R5: word write leaves phase alone
    set_freq(0);
    preset(MOD - 3);
    set_freq(1);
    clr();
    run(2);
    chk("R5 no tick before phase wraps", n_tick, 0);
    run(1);
    chk("R5 tick on third sample", n_tick, 1);

    // R7: phase write in update mode ignored
    set_freq(1);
    preset(0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; preset_mode = 1'b0; wr_data = W'(MOD - 1);
    @(negedge clk);
    wr_en = 1'b0;
    clr();
    run(1);
    chk("R7 update-mode phase write ignored", n_tick, 0);

    // R6: preset in a carrying sample cycle suppresses the tick and loads phase
    set_freq(1);
    preset(MOD - 1);
    @(negedge clk);
    samp_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; preset_mode = 1'b1; wr_data = W'(5);
    @(negedge clk);
    samp_en = 1'b0; wr_en = 1'b0; preset_mode = 1'b0;
    chk("R6 half_tick suppressed", half_tick, 0);
    chk("R6 chip_strobe suppressed", chip_strobe, 0);
    set_freq(MOD - 5);
    clr();
    run(1);
    chk("R6 preset phase loaded exactly", n_tick, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule